// File: doc/BRIEF.md
# BCD Calendar Timekeeper with Frozen Readout

This block keeps the time and date in packed BCD. It counts hundredths of a second, seconds, minutes, hours, day of week, day of month, month and two-digit year. A one-cycle pulse at 100 Hz drives it. The block holds two copies of the time. The internal counters advance on every enabled tick. A second, user-visible copy is what the register port reads.

A transfer-enable control sets how the visible copy follows the counters. While it is set, the visible copy takes the hundredths on every tick and the rest of the fields on each hundredths rollover. While it is clear, the visible copy stays frozen and the counters keep running, so software can read a consistent snapshot without losing time.

The month register holds two control bits:
- an active-low oscillator enable, which gates the ticks;
- an active-low enable for a 1024 Hz square-wave output.

When the square wave is off, its output enable drops, which stands in for a high-impedance pin. The hours register supports both 24-hour and 12-hour formats, the latter with an AM/PM flag.

Top module: `bcd_timekeeper`

## Requirements
- R1: After reset the visible registers read as follows:
  - hundredths, seconds, minutes, hours and year: 00
  - day of week: 01
  - date: 01
  - month register: C1h (oscillator stopped, square wave off, January)
  - control register (address Bh): 80h (transfer enabled)
  - `sqw_oe`: 0
- R2: The time registers are at the following addresses, and bits outside each mask always read 0 whatever is written:

  | Address | Field | Readable bits |
  |---|---|---|
  | 0 | hundredths | FFh |
  | 1 | seconds | 7Fh |
  | 2 | minutes | 7Fh |
  | 4 | hours | 7Fh |
  | 6 | day of week | 07h |
  | 8 | date | 3Fh |
  | 9 | month | DFh (bits 7 and 6 are controls) |
  | Ah | year | FFh |
- R3: Each enabled tick adds one to hundredths in BCD. A tick at 99 gives 00, and on that tick the carry passes from seconds (59 to 00) to minutes (59 to 00) to hours.
- R4: With hours bit 6 at 0 (24-hour format), hours counts 00 to 23. On a tick at 23:59:59.99, hours goes to 00 and the day advances.
- R5: With hours bit 6 at 1 (12-hour format), bit 5 is PM and bits 4:0 hold 01 to 12.
  - 11 goes to 12 and toggles PM.
  - 12 goes to 01.
  - 11 PM rolling to 12 AM advances the day.
- R6: The last date of a month is:
  - 31, except for months 04, 06, 09 and 11, which end at 30;
  - for month 02: 29 when the binary value of the BCD year is divisible by 4, otherwise 28.
- R7: When the day advances past the last date, the date goes to 01 and the month increments. Month 12 wraps to 01 and increments the year, and year 99 wraps to 00.
- R8: Day of week increments on every day advance and wraps from 7 to 1.
- R9: Transfer enable is bit 7 of address Bh.
  - While it is 0, the visible registers hold their values and the internal counters keep advancing.
  - While it is 1, each enabled tick copies the new hundredths to the visible copy.
  - A tick that rolls hundredths from 99 to 00 copies all fields.
- R10: A write to a time register updates the visible copy and the internal counter in the same cycle, whatever the transfer-enable value.
- R11: A tick is ignored while month bit 7 is 1 or `osc_ok` is low.
- R12: With month bit 6 at 0, `sqw_oe` is 1 and `sqw_out` follows `ref_1024hz` one cycle later. With bit 6 at 1, both are 0.
- R13: Read data is registered and reflects `addr` one clock after it is presented.
  - Addresses 3, 5, 7 and Ch to Fh read 00, and writes to them have no effect.
  - Address Bh reads bits 6:0 as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_100hz | input | 1 | One-cycle pulse at 100 Hz |
| osc_ok | input | 1 | Oscillator running; gates ticks |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| ref_1024hz | input | 1 | 1024 Hz reference square wave |
| sqw_out | output | 1 | Gated square-wave output |
| sqw_oe | output | 1 | Square-wave output enable |

## Verification
A wrong internal counter stays hidden while transfer enable is clear. It surfaces in the visible copy on the first hundredths rollover after the enable is set again, so the bench reads back across a freeze and resume window. A carry fault in the date or month logic shows only on the last day of a month. The bench therefore sweeps every month over leap and non-leap years and reads both the date before the last and the rollover. A fault in the hundredths path appears at the read port two cycles after the faulty tick.

// File: rtl/tk_pkg.sv
package tk_pkg;

  typedef struct packed {
    logic [7:0] hund;
    logic [7:0] sec;
    logic [7:0] min;
    logic [7:0] hr;
    logic [7:0] dow;
    logic [7:0] date;
    logic [7:0] mon;
    logic [7:0] year;
  } tk_time_t;

  localparam int A_HUND = 0;
  localparam int A_SEC  = 1;
  localparam int A_MIN  = 2;
  localparam int A_HR   = 4;
  localparam int A_DOW  = 6;
  localparam int A_DATE = 8;
  localparam int A_MON  = 9;
  localparam int A_YEAR = 10;
  localparam int A_CTRL = 11;

  localparam logic [7:0] M_HUND = 8'hFF;
  localparam logic [7:0] M_SEC  = 8'h7F;
  localparam logic [7:0] M_MIN  = 8'h7F;
  localparam logic [7:0] M_HR   = 8'h7F;
  localparam logic [7:0] M_DOW  = 8'h07;
  localparam logic [7:0] M_DATE = 8'h3F;
  localparam logic [7:0] M_MON  = 8'h1F;
  localparam logic [7:0] M_YEAR = 8'hFF;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [6:0] bcd_bin(input logic [7:0] v);
    return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
  endfunction

  function automatic logic [7:0] month_last(input logic [7:0] mon,
                                            input logic [7:0] year);
    logic [6:0] m;
    logic [6:0] y;
    m = bcd_bin(mon);
    y = bcd_bin(year);
    if (m == 7'd2) return (y[1:0] == 2'b00) ? 8'h29 : 8'h28;
    if (m == 7'd4 || m == 7'd6 || m == 7'd9 || m == 7'd11) return 8'h30;
    return 8'h31;
  endfunction

endpackage

// File: rtl/tk_advance.sv
module tk_advance
  import tk_pkg::*;
(
  input  tk_time_t cur,
  output tk_time_t nxt,
  output logic     roll
);

  logic       c_min, c_hr, c_day, c_mon, c_year;
  logic       pm_n;
  logic [4:0] h12;
  logic [5:0] h24;

  always_comb begin
    nxt   = cur;
    c_min = 1'b0;
    c_hr  = 1'b0;
    c_day = 1'b0;
    c_mon = 1'b0;
    c_year = 1'b0;
    pm_n  = cur.hr[5];
    h12   = cur.hr[4:0];
    h24   = cur.hr[5:0];
    roll  = (cur.hund == 8'h99);

    nxt.hund = roll ? 8'h00 : bcd_inc(cur.hund);

    if (roll) begin
      if (cur.sec == 8'h59) begin
        nxt.sec = 8'h00;
        c_min   = 1'b1;
      end else begin
        nxt.sec = bcd_inc(cur.sec);
      end
    end

    if (c_min) begin
      if (cur.min == 8'h59) begin
        nxt.min = 8'h00;
        c_hr    = 1'b1;
      end else begin
        nxt.min = bcd_inc(cur.min);
      end
    end

    if (c_hr) begin
      if (cur.hr[6]) begin
        if (cur.hr[4:0] == 5'h11) begin
          h12   = 5'h12;
          pm_n  = ~cur.hr[5];
          c_day = cur.hr[5];
        end else if (cur.hr[4:0] == 5'h12) begin
          h12 = 5'h01;
        end else begin
          h12 = 5'(bcd_inc({3'b000, cur.hr[4:0]}));
        end
        nxt.hr = {1'b0, 1'b1, pm_n, h12};
      end else begin
        if (cur.hr[5:0] == 6'h23) begin
          h24   = 6'h00;
          c_day = 1'b1;
        end else begin
          h24 = 6'(bcd_inc({2'b00, cur.hr[5:0]}));
        end
        nxt.hr = {2'b00, h24};
      end
    end

    if (c_day) begin
      nxt.dow = (cur.dow == 8'h07) ? 8'h01 : cur.dow + 8'h01;
      if (cur.date == month_last(cur.mon, cur.year)) begin
        nxt.date = 8'h01;
        c_mon    = 1'b1;
      end else begin
        nxt.date = bcd_inc(cur.date);
      end
    end

    if (c_mon) begin
      if (cur.mon == 8'h12) begin
        nxt.mon = 8'h01;
        c_year  = 1'b1;
      end else begin
        nxt.mon = bcd_inc(cur.mon);
      end
    end

    if (c_year) nxt.year = (cur.year == 8'h99) ? 8'h00 : bcd_inc(cur.year);
  end

endmodule

// File: rtl/tk_readmux.sv
module tk_readmux
  import tk_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  tk_time_t          vis,
  input  logic              te,
  input  logic              eosc_n,
  input  logic              sqw_n,
  output logic [DATA_W-1:0] rdata
);

  logic [7:0] sel;

  always_comb begin
    sel = 8'h00;
    case (int'(addr))
      A_HUND:  sel = vis.hund & M_HUND;
      A_SEC:   sel = vis.sec  & M_SEC;
      A_MIN:   sel = vis.min  & M_MIN;
      A_HR:    sel = vis.hr   & M_HR;
      A_DOW:   sel = vis.dow  & M_DOW;
      A_DATE:  sel = vis.date & M_DATE;
      A_MON:   sel = {eosc_n, sqw_n, 1'b0, vis.mon[4:0]};
      A_YEAR:  sel = vis.year & M_YEAR;
      A_CTRL:  sel = {te, 7'b0};
      default: sel = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= DATA_W'(sel);
  end

endmodule

// File: rtl/tk_sqw.sv
module tk_sqw (
  input  logic clk,
  input  logic rst,
  input  logic ref_in,
  input  logic off_n,
  output logic wave,
  output logic wave_oe
);

  always_ff @(posedge clk) begin
    if (rst) begin
      wave    <= 1'b0;
      wave_oe <= 1'b0;
    end else begin
      wave    <= ref_in & ~off_n;
      wave_oe <= ~off_n;
    end
  end

endmodule

// File: rtl/bcd_timekeeper.sv
module bcd_timekeeper
  import tk_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_100hz,
  input  logic              osc_ok,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              ref_1024hz,
  output logic              sqw_out,
  output logic              sqw_oe
);

  localparam tk_time_t RST_TIME = '{hund: 8'h00, sec: 8'h00, min: 8'h00,
                                    hr: 8'h00, dow: 8'h01, date: 8'h01,
                                    mon: 8'h01, year: 8'h00};

  tk_time_t   cnt_q;
  tk_time_t   vis_q;
  tk_time_t   cnt_nxt;
  logic       roll;
  logic       te_q;
  logic       eosc_n_q;
  logic       sqw_n_q;
  logic       run;
  logic [7:0] wd;

  assign run = tick_100hz & osc_ok & ~eosc_n_q;
  assign wd  = wdata[7:0];

  tk_advance u_adv (
    .cur  (cnt_q),
    .nxt  (cnt_nxt),
    .roll (roll)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= RST_TIME;
      vis_q    <= RST_TIME;
      te_q     <= 1'b1;
      eosc_n_q <= 1'b1;
      sqw_n_q  <= 1'b1;
    end else begin
      if (run) begin
        cnt_q <= cnt_nxt;
        if (te_q) begin
          if (roll) vis_q      <= cnt_nxt;
          else      vis_q.hund <= cnt_nxt.hund;
        end
      end
      if (wr_en) begin
        case (int'(addr))
          A_HUND: begin cnt_q.hund <= wd & M_HUND; vis_q.hund <= wd & M_HUND; end
          A_SEC:  begin cnt_q.sec  <= wd & M_SEC;  vis_q.sec  <= wd & M_SEC;  end
          A_MIN:  begin cnt_q.min  <= wd & M_MIN;  vis_q.min  <= wd & M_MIN;  end
          A_HR:   begin cnt_q.hr   <= wd & M_HR;   vis_q.hr   <= wd & M_HR;   end
          A_DOW:  begin cnt_q.dow  <= wd & M_DOW;  vis_q.dow  <= wd & M_DOW;  end
          A_DATE: begin cnt_q.date <= wd & M_DATE; vis_q.date <= wd & M_DATE; end
          A_MON: begin
            cnt_q.mon <= wd & M_MON;
            vis_q.mon <= wd & M_MON;
            eosc_n_q  <= wd[7];
            sqw_n_q   <= wd[6];
          end
          A_YEAR: begin cnt_q.year <= wd & M_YEAR; vis_q.year <= wd & M_YEAR; end
          A_CTRL: te_q <= wd[7];
          default: ;
        endcase
      end
    end
  end

  tk_readmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk    (clk),
    .rst    (rst),
    .addr   (addr),
    .vis    (vis_q),
    .te     (te_q),
    .eosc_n (eosc_n_q),
    .sqw_n  (sqw_n_q),
    .rdata  (rdata)
  );

  tk_sqw u_sqw (
    .clk     (clk),
    .rst     (rst),
    .ref_in  (ref_1024hz),
    .off_n   (sqw_n_q),
    .wave    (sqw_out),
    .wave_oe (sqw_oe)
  );

endmodule

module tk_checker #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              osc_ok,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rdata,
  input logic              sqw_out,
  input logic              sqw_oe,
  input logic              eosc_n,
  input logic              te,
  input logic [7:0]        int_hund,
  input logic [7:0]        vis_hund,
  input logic [7:0]        vis_sec
);

  a_r11_hold_when_stopped: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && (!osc_ok || eosc_n)) |=> $stable(int_hund));

  a_r9_frozen_visible: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !te) |=> ($stable(vis_hund) && $stable(vis_sec)));

  a_r9_copy_on_tick: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && te && tick && osc_ok && !eosc_n) |=> (vis_hund == int_hund));

  a_r3_hund_step: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && tick && osc_ok && !eosc_n && int_hund == 8'h42) |=> (int_hund == 8'h43));

  a_r3_hund_wrap: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && tick && osc_ok && !eosc_n && int_hund == 8'h99) |=> (int_hund == 8'h00));

  a_r12_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
    !sqw_oe |-> !sqw_out);

  a_r13_unused_zero: assert property (@(posedge clk) disable iff (rst)
    (addr == ADDR_W'(3)) |=> (rdata == '0));

endmodule

bind bcd_timekeeper tk_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .tick     (tick_100hz),
  .osc_ok   (osc_ok),
  .wr_en    (wr_en),
  .addr     (addr),
  .rdata    (rdata),
  .sqw_out  (sqw_out),
  .sqw_oe   (sqw_oe),
  .eosc_n   (eosc_n_q),
  .te       (te_q),
  .int_hund (cnt_q.hund),
  .vis_hund (vis_q.hund),
  .vis_sec  (vis_q.sec)
);

// File: tb/tb_bcd_timekeeper.sv
`timescale 1ns/1ps
module tb_bcd_timekeeper;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_100hz = 1'b0;
  logic       osc_ok = 1'b1;
  logic       wr_en = 1'b0;
  logic [3:0] addr = 4'h0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       ref_1024hz = 1'b0;
  logic       sqw_out;
  logic       sqw_oe;

  int checks = 0;
  int errors = 0;
  logic [7:0] ylist [4] = '{8'h00, 8'h03, 8'h04, 8'h99};

  always #2.5 clk = ~clk;

  bcd_timekeeper dut (
    .clk(clk), .rst(rst), .tick_100hz(tick_100hz), .osc_ok(osc_ok),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .ref_1024hz(ref_1024hz), .sqw_out(sqw_out), .sqw_oe(sqw_oe)
  );

  function automatic logic [7:0] tobcd(input int n);
    return 8'(((n / 10) << 4) | (n % 10));
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    v = rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_100hz = 1'b1;
      @(negedge clk); tick_100hz = 1'b0;
    end
  endtask

  task automatic set_eod(input logic [7:0] hr);
    wr(4'h4, hr); wr(4'h2, 8'h59); wr(4'h1, 8'h59); wr(4'h0, 8'h99);
  endtask

  task automatic rchk(input string req, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset values
    rchk("R1 hund", 4'h0, 8'h00); rchk("R1 sec", 4'h1, 8'h00);
    rchk("R1 min", 4'h2, 8'h00);  rchk("R1 hr", 4'h4, 8'h00);
    rchk("R1 dow", 4'h6, 8'h01);  rchk("R1 date", 4'h8, 8'h01);
    rchk("R1 mon", 4'h9, 8'hC1);  rchk("R1 year", 4'hA, 8'h00);
    rchk("R1 ctrl", 4'hB, 8'h80);
    chk("R1 sqw_oe", {7'b0, sqw_oe}, 8'h00);

    // R11 oscillator stopped after reset: ticks ignored
    ticks(5);
    rchk("R11 stopped at reset", 4'h0, 8'h00);

    // R2 unused bits read zero
    wr(4'h1, 8'hFF); rchk("R2 sec mask", 4'h1, 8'h7F);
    wr(4'h2, 8'hFF); rchk("R2 min mask", 4'h2, 8'h7F);
    wr(4'h4, 8'hFF); rchk("R2 hr mask", 4'h4, 8'h7F);
    wr(4'h6, 8'hFF); rchk("R2 dow mask", 4'h6, 8'h07);
    wr(4'h8, 8'hFF); rchk("R2 date mask", 4'h8, 8'h3F);
    wr(4'h9, 8'hFF); rchk("R2 mon mask", 4'h9, 8'hDF);

    // R13 unused addresses and control bits
    wr(4'h3, 8'hFF); rchk("R13 addr3", 4'h3, 8'h00);
    wr(4'hC, 8'hFF); rchk("R13 addrC", 4'hC, 8'h00);
    wr(4'hF, 8'hFF); rchk("R13 addrF", 4'hF, 8'h00);
    wr(4'hB, 8'hFF); rchk("R13 ctrl bits", 4'hB, 8'h80);

    // restore a sane time, oscillator on, square wave off
    wr(4'h9, 8'h41); wr(4'h8, 8'h01); wr(4'h6, 8'h03); wr(4'h4, 8'h00);
    wr(4'h2, 8'h00); wr(4'h1, 8'h00); wr(4'h0, 8'h00); wr(4'hA, 8'h00);

    // R3 hundredths step and carry chain
    wr(4'h0, 8'h42); ticks(1); rchk("R3 step", 4'h0, 8'h43);
    wr(4'h0, 8'h09); ticks(1); rchk("R3 digit carry", 4'h0, 8'h10);
    set_eod(8'h09); ticks(1);
    rchk("R3 hund wrap", 4'h0, 8'h00); rchk("R3 sec wrap", 4'h1, 8'h00);
    rchk("R3 min wrap", 4'h2, 8'h00);  rchk("R3 hour carry", 4'h4, 8'h10);

    // R4 24-hour
    set_eod(8'h19); ticks(1); rchk("R4 19 to 20", 4'h4, 8'h20);
    wr(4'h8, 8'h10); wr(4'h6, 8'h03);
    set_eod(8'h23); ticks(1);
    rchk("R4 23 to 00", 4'h4, 8'h00); rchk("R4 day advance", 4'h8, 8'h11);
    rchk("R8 dow 3 to 4", 4'h6, 8'h04);

    // R5 12-hour
    set_eod(8'h51); ticks(1); rchk("R5 11AM to 12PM", 4'h4, 8'h72);
    rchk("R5 no day at noon", 4'h8, 8'h11);
    set_eod(8'h72); ticks(1); rchk("R5 12PM to 1PM", 4'h4, 8'h61);
    set_eod(8'h49); ticks(1); rchk("R5 9AM to 10AM", 4'h4, 8'h50);
    wr(4'h6, 8'h07);
    set_eod(8'h71); ticks(1); rchk("R5 11PM to 12AM", 4'h4, 8'h52);
    rchk("R5 day advance", 4'h8, 8'h12);
    rchk("R8 dow 7 to 1", 4'h6, 8'h01);

    // R6 R7 month length sweep over leap and non-leap years
    for (int yi = 0; yi < 4; yi++) begin
      int ybin;
      ybin = int'(ylist[yi][7:4]) * 10 + int'(ylist[yi][3:0]);
      for (int m = 1; m <= 12; m++) begin
        int last;
        if (m == 2) last = (ybin % 4 == 0) ? 29 : 28;
        else if (m == 4 || m == 6 || m == 9 || m == 11) last = 30;
        else last = 31;
        wr(4'hA, ylist[yi]); wr(4'h9, 8'h40 | tobcd(m)); wr(4'h8, tobcd(last - 1));
        set_eod(8'h23); ticks(1);
        rchk("R6 reach last date", 4'h8, tobcd(last));
        set_eod(8'h23); ticks(1);
        rchk("R7 date wrap", 4'h8, 8'h01);
        rchk("R7 month next", 4'h9, 8'h40 | tobcd((m == 12) ? 1 : m + 1));
        rchk("R7 year", 4'hA, (m == 12) ? tobcd((ybin + 1) % 100) : ylist[yi]);
      end
    end

    // R9 freeze and resume
    wr(4'h9, 8'h41); wr(4'h4, 8'h00); wr(4'h2, 8'h00);
    wr(4'h1, 8'h00); wr(4'h0, 8'h00);
    wr(4'hB, 8'h00); ticks(150);
    rchk("R9 frozen hund", 4'h0, 8'h00); rchk("R9 frozen sec", 4'h1, 8'h00);
    wr(4'hB, 8'h80); ticks(1);
    rchk("R9 hund resumes", 4'h0, 8'h51); rchk("R9 sec waits", 4'h1, 8'h00);
    ticks(49);
    rchk("R9 rollover copy hund", 4'h0, 8'h00);
    rchk("R9 rollover copy sec", 4'h1, 8'h02);

    // R10 writes reach internal counters while frozen
    wr(4'hB, 8'h00); wr(4'h0, 8'h10); wr(4'h1, 8'h30);
    rchk("R10 visible written", 4'h1, 8'h30);
    ticks(5);
    rchk("R10 visible frozen", 4'h0, 8'h10);
    wr(4'hB, 8'h80); ticks(85);
    rchk("R10 internal hund", 4'h0, 8'h00);
    rchk("R10 internal sec", 4'h1, 8'h31);

    // R11 oscillator gating
    wr(4'h0, 8'h00); wr(4'h9, 8'hC1); ticks(10);
    rchk("R11 month bit7 stops", 4'h0, 8'h00);
    wr(4'h9, 8'h41); osc_ok = 1'b0; ticks(10);
    rchk("R11 osc_ok low stops", 4'h0, 8'h00);
    osc_ok = 1'b1; ticks(3);
    rchk("R11 resumes", 4'h0, 8'h03);

    // R12 square wave
    @(negedge clk); ref_1024hz = 1'b1;
    @(negedge clk);
    chk("R12 oe off", {7'b0, sqw_oe}, 8'h00);
    chk("R12 out off", {7'b0, sqw_out}, 8'h00);
    wr(4'h9, 8'h01);
    @(negedge clk);
    chk("R12 oe on", {7'b0, sqw_oe}, 8'h01);
    chk("R12 out high", {7'b0, sqw_out}, 8'h01);
    ref_1024hz = 1'b0;
    @(negedge clk);
    chk("R12 out low", {7'b0, sqw_out}, 8'h00);
    ref_1024hz = 1'b1;
    @(negedge clk);
    chk("R12 out follows", {7'b0, sqw_out}, 8'h01);
    wr(4'h9, 8'h41);
    @(negedge clk);
    chk("R12 oe off again", {7'b0, sqw_oe}, 8'h00);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule